// File: doc/BRIEF.md
# Interrupt Line Remap Matrix

This block sits in front of an interrupt controller's pending register and steers a wide set of peripheral request lines onto the controller's smaller set of interrupt numbers. Every request line has its own programmable target field. That field names either a primary interrupt number (1 to 15) or an extended number (16 up to the top of the field range). A field of zero leaves the line disconnected. When several lines share a target, their requests are merged with a logical OR. Any request routed to an extended number also raises the summary bit, bit 1. This is how the controller learns that an extended source is active.

Software loads one target field per write through a small register-write port. The block produces a set vector, one bit per interrupt number, registered once. The controller uses this vector to raise pending bits. The request lines are level inputs. The set vector follows them every cycle and holds no state of its own. Priority, masking and acknowledgement belong to the controller and are not handled here.

Top module: `irq_remap_matrix`

## Requirements
- R1: After reset every target field is 0 and the set vector is all zeros. While the fields stay at 0, asserting every request line leaves the set vector at zero.
- R2: A line whose target field is 0 sets no bit of the set vector.
- R3: A line with target field value n, where 2 <= n <= 15, sets only bit n of the set vector.
- R4: A line with target field value 1 sets only bit 1 of the set vector.
- R5: A line with target field value n, where 16 <= n <= 31, sets bit n and bit 1 of the set vector and no other bit.
- R6: When several lines target the same number, that bit is the OR of their requests. Each bit of the set vector is the OR over all lines that drive it.
- R7: Bit 0 of the set vector is always 0.
- R8: The set vector is registered. A request level sampled at a clock edge appears on the output after that edge. A target field written at one edge first affects the output after the following edge.
- R9: A write with enable high loads the data into the field of the addressed line only. Every other field keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| irq_i | input | NUM_SRC (64) | Peripheral request levels, one per line |
| wr_en_i | input | 1 | Target field write strobe |
| wr_idx_i | input | IDX_W (6) | Index of the line whose field is written |
| wr_field_i | input | FIELD_W (5) | New target field value |
| set_o | output | 2**FIELD_W (32) | Registered set vector toward the pending register |

## Verification
A request level changes the set vector one clock edge after it is sampled. A field write takes two edges to reach the output: one edge loads the field, and the next edge computes the output from it. The bench drives all inputs on the falling edge and samples the set vector on the next falling edge. After a write it waits one extra falling edge. One dedicated check reads the output right after the write edge, where the old mapping must still be visible. Another check reads the output a moment after the request lines change, before any rising edge, where the output must still hold its previous value.

// File: rtl/irq_remap_pkg.sv
package irq_remap_pkg;
   // default configuration of the matrix
   localparam int DEF_NUM_SRC  = 64;
   localparam int DEF_FIELD_W  = 5;
   localparam int DEF_EXT_BASE = 16;
   // pending-vector bit raised for any extended target
   localparam int SUMMARY_BIT  = 1;
endpackage

// File: rtl/irq_remap_field_bank.sv
module irq_remap_field_bank #(
   parameter int NUM_SRC = irq_remap_pkg::DEF_NUM_SRC,
   parameter int FIELD_W = irq_remap_pkg::DEF_FIELD_W,
   parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic                       wr_en_i,
   input  logic [IDX_W-1:0]           wr_idx_i,
   input  logic [FIELD_W-1:0]         wr_field_i,
   output logic [NUM_SRC*FIELD_W-1:0] map_o
);
   logic [FIELD_W-1:0] field_q [NUM_SRC];

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_field
      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            field_q[s] <= '0;
         end else if (wr_en_i && (wr_idx_i == IDX_W'(s))) begin
            field_q[s] <= wr_field_i;
         end
      end
      assign map_o[s*FIELD_W +: FIELD_W] = field_q[s];
   end
endmodule

// File: rtl/irq_remap_line_decode.sv
module irq_remap_line_decode #(
   parameter int FIELD_W  = irq_remap_pkg::DEF_FIELD_W,
   parameter int EXT_BASE = irq_remap_pkg::DEF_EXT_BASE,
   parameter int NUM_TGT  = 1 << FIELD_W
) (
   input  logic               req_i,
   input  logic [FIELD_W-1:0] field_i,
   output logic [NUM_TGT-1:0] hit_o
);
   localparam bit HAS_EXT = (EXT_BASE < NUM_TGT);

   logic ext_sel;

   // variant: summary logic only exists when extended numbers fit the field
   if (HAS_EXT) begin : g_ext
      assign ext_sel = (field_i >= FIELD_W'(EXT_BASE));
   end else begin : g_no_ext
      assign ext_sel = 1'b0;
   end

   always_comb begin
      hit_o = '0;
      for (int t = 1; t < NUM_TGT; t++) begin
         if (int'(field_i) == t) hit_o[t] = req_i;
      end
      if (ext_sel) hit_o[irq_remap_pkg::SUMMARY_BIT] = req_i;
   end
endmodule

// File: rtl/irq_remap_merge.sv
module irq_remap_merge #(
   parameter int NUM_SRC = irq_remap_pkg::DEF_NUM_SRC,
   parameter int NUM_TGT = 1 << irq_remap_pkg::DEF_FIELD_W
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic [NUM_SRC*NUM_TGT-1:0] hits_i,
   output logic [NUM_TGT-1:0]         set_o
);
   logic [NUM_TGT-1:0] set_d;

   for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
      logic [NUM_SRC-1:0] column;
      for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
         assign column[s] = hits_i[s*NUM_TGT + t];
      end
      assign set_d[t] = |column;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) set_o <= '0;
      else         set_o <= set_d;
   end
endmodule

// File: rtl/irq_remap_matrix.sv
module irq_remap_matrix #(
   parameter int NUM_SRC  = irq_remap_pkg::DEF_NUM_SRC,
   parameter int FIELD_W  = irq_remap_pkg::DEF_FIELD_W,
   parameter int EXT_BASE = irq_remap_pkg::DEF_EXT_BASE,
   localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
   localparam int NUM_TGT = 1 << FIELD_W
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] irq_i,
   input  logic               wr_en_i,
   input  logic [IDX_W-1:0]   wr_idx_i,
   input  logic [FIELD_W-1:0] wr_field_i,
   output logic [NUM_TGT-1:0] set_o
);
   // elaboration-time parameter checks
   if (NUM_SRC < 1) begin : g_bad_src
      $error("irq_remap_matrix: NUM_SRC must be at least 1");
   end
   if (FIELD_W < 2 || FIELD_W > 8) begin : g_bad_field
      $error("irq_remap_matrix: FIELD_W must lie in 2..8");
   end
   if (EXT_BASE <= irq_remap_pkg::SUMMARY_BIT + 1 || EXT_BASE > NUM_TGT) begin : g_bad_ext
      $error("irq_remap_matrix: EXT_BASE out of range");
   end

   logic [NUM_SRC*FIELD_W-1:0] map;
   logic [NUM_SRC*NUM_TGT-1:0] hits;

   irq_remap_field_bank #(
      .NUM_SRC (NUM_SRC),
      .FIELD_W (FIELD_W),
      .IDX_W   (IDX_W)
   ) bank_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (wr_en_i),
      .wr_idx_i   (wr_idx_i),
      .wr_field_i (wr_field_i),
      .map_o      (map)
   );

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_line
      irq_remap_line_decode #(
         .FIELD_W  (FIELD_W),
         .EXT_BASE (EXT_BASE),
         .NUM_TGT  (NUM_TGT)
      ) dec_i (
         .req_i   (irq_i[s]),
         .field_i (map[s*FIELD_W +: FIELD_W]),
         .hit_o   (hits[s*NUM_TGT +: NUM_TGT])
      );
   end

   irq_remap_merge #(
      .NUM_SRC (NUM_SRC),
      .NUM_TGT (NUM_TGT)
   ) merge_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .hits_i (hits),
      .set_o  (set_o)
   );
endmodule

// File: rtl/irq_remap_matrix_chk.sv
module irq_remap_matrix_chk #(
   parameter int NUM_SRC  = irq_remap_pkg::DEF_NUM_SRC,
   parameter int FIELD_W  = irq_remap_pkg::DEF_FIELD_W,
   parameter int EXT_BASE = irq_remap_pkg::DEF_EXT_BASE,
   localparam int NUM_TGT = 1 << FIELD_W
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic [NUM_SRC-1:0] irq_i,
   input logic               wr_en_i,
   input logic [NUM_TGT-1:0] set_o
);
   // R1: a reset edge clears the set vector
   a_r1_reset_clears: assert property (@(posedge clk_i)
      !rst_ni |=> (set_o == '0));

   // R7: bit 0 never raised
   a_r7_bit0_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_o[0] == 1'b0));

   // R5: any extended bit implies the summary bit
   a_r5_summary: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|set_o[NUM_TGT-1:EXT_BASE]) |-> set_o[irq_remap_pkg::SUMMARY_BIT]);

   // R2: no requests at an edge leave an empty vector after it
   a_r2_idle_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_i == '0) |=> (set_o == '0));

   // R8: steady requests and no recent write keep the output steady
   a_r8_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $stable(irq_i) && !$past(wr_en_i)) |=> $stable(set_o));
endmodule

bind irq_remap_matrix irq_remap_matrix_chk #(
   .NUM_SRC  (NUM_SRC),
   .FIELD_W  (FIELD_W),
   .EXT_BASE (EXT_BASE)
) chk_i (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .irq_i   (irq_i),
   .wr_en_i (wr_en_i),
   .set_o   (set_o)
);

// File: tb/irq_remap_matrix_tb_top.sv
`timescale 1ns/1ps
module irq_remap_matrix_tb_top;
   localparam int NS = 64;
   localparam int FW = 5;
   localparam int NT = 32;
   localparam int XB = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] irq = '0;
   logic          wr_en = 1'b0;
   logic [5:0]    wr_idx = '0;
   logic [FW-1:0] wr_field = '0;
   logic [NT-1:0] set_vec;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   int mdl [NS];

   always #2 clk = ~clk;

   irq_remap_matrix dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .irq_i      (irq),
      .wr_en_i    (wr_en),
      .wr_idx_i   (wr_idx),
      .wr_field_i (wr_field),
      .set_o      (set_vec)
   );

   function automatic logic [NT-1:0] model(logic [NS-1:0] v);
      logic [NT-1:0] e = '0;
      for (int i = 0; i < NS; i++) begin
         if (v[i] && mdl[i] != 0) begin
            e[mdl[i]] = 1'b1;
            if (mdl[i] >= XB) e[1] = 1'b1;
         end
      end
      return e;
   endfunction

   function automatic string tag_of(int v);
      if (v == 0) return "R2";
      if (v == 1) return "R4";
      if (v < XB) return "R3";
      return "R5";
   endfunction

   task automatic check(logic [NT-1:0] act, logic [NT-1:0] exp, string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic do_write(int idx, int val);
      wr_en = 1'b1; wr_idx = 6'(idx); wr_field = FW'(val);
      @(negedge clk);
      wr_en = 1'b0;
      mdl[idx] = val;
   endtask

   task automatic drive_check(logic [NS-1:0] v, string tag);
      irq = v;
      @(negedge clk);
      check(set_vec, model(v), tag);
   endtask

   initial begin
      logic [NS-1:0] lfsr;
      for (int i = 0; i < NS; i++) mdl[i] = 0;
      irq = '1;
      repeat (3) @(negedge clk);
      check(set_vec, '0, "R1 reset value");
      rst_n = 1'b1;
      @(negedge clk);
      check(set_vec, '0, "R1 all lines high with zero fields");

      // sweep every line against every field value
      for (int i = 0; i < NS; i++) begin
         for (int v = 0; v < NT; v++) begin
            do_write(i, v);
            drive_check(NS'(1) << i, tag_of(v));
            drive_check('1, "R9 only addressed field set");
            check({31'd0, set_vec[0]}, '0, "R7 bit0");
         end
         do_write(i, 0);
      end

      // R8 latency of a field write and of a request
      irq = '0;
      @(negedge clk);
      irq = NS'(1) << 3;
      #1 check(set_vec, '0, "R8 output holds before edge");
      @(negedge clk);
      check(set_vec, '0, "R8 field 0 line 3");
      wr_en = 1'b1; wr_idx = 6'd3; wr_field = 5'd9;
      @(negedge clk);
      wr_en = 1'b0;
      check(set_vec, '0, "R8 old mapping after write edge");
      mdl[3] = 9;
      @(negedge clk);
      check(set_vec, NT'(1) << 9, "R8 new mapping one edge later");

      // R6 merging with shared targets
      for (int i = 0; i < NS; i++) do_write(i, (i % 31) + 1);
      lfsr = 64'hACE1_2468_9BDF_1357;
      for (int p = 0; p < 40; p++) begin
         lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
         drive_check(lfsr, "R6 merged pattern");
      end
      drive_check((NS'(1) << 0) | (NS'(1) << 31), "R6 two lines one target");
      drive_check(NS'(1) << 31, "R6 one of shared pair");
      drive_check('1, "R6 all lines");
      check({31'd0, set_vec[0]}, '0, "R7 bit0 full load");

      // R1 reset again clears the fields
      rst_n = 1'b0;
      @(negedge clk);
      check(set_vec, '0, "R1 reset mid-run");
      rst_n = 1'b1;
      for (int i = 0; i < NS; i++) mdl[i] = 0;
      drive_check('1, "R1 fields cleared by reset");

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule